// File: doc/BRIEF.md
# Dual-Ramp Charge-Transfer Sequencer

This block times one charge-transfer half period of a zero-crossing-based pipeline gain stage. A fast clock runs it; a slower half-clock phase input marks when the stage transfers charge. Each time that phase input goes high, the block emits a fixed-width preset pulse and turns on both ramp current sources at the same time. It then waits for the coarse threshold detector, and at that point it fires the early decision strobe for the next stage's sub-ADC while the fine ramp continues alone. When the fine detector trips, it opens the sampling switches, and a fixed number of cycles later it turns off the fine ramp.

The detector trip inputs are asynchronous. Each one passes through a synchronizer, and the block acts only on its rising edge. A trip edge that arrives outside its own phase has no effect. If the phase input falls before the fine trip has arrived, the block forces the sampling control low, stops every ramp and raises a sticky timeout flag. The stage output pull-up and the large preamplifier bias are derived from the same sequence. The small bias is held on at all times.

Top module: `ztx_phase_seq`

## Requirements
- R1: After reset the following outputs are low: preset, both ramp enables, strobe, sampling control, large bias and timeout. The pull-up output and the small-bias output are high.
- R2: Once the phase input is seen low at one rising clock edge and high at the next, the outputs change after that second edge: preset, coarse enable, fine enable and sampling control all go high together. Preset stays high for exactly PRESET_CYC cycles.
- R3: The coarse phase starts when preset ends, and coarse enable stays high through it. A coarse trip input that first goes high before clock edge n ends the coarse phase after edge n+2. The synchronizer is two flops deep by default, and only the rising edge of the trip counts.
- R4: The sub-ADC strobe is a single-cycle pulse. It is high in the first cycle after the coarse phase ends on a trip, and in no other cycle.
- R5: The fine phase starts after the coarse phase. A fine trip input that first goes high before edge n drops the sampling control after edge n+2. Fine enable then stays high for SHUT_CYC more cycles and drops afterwards.
- R6: The large bias is high exactly during the coarse and fine phases. The small bias is always high.
- R7: The pull-up output is low during the preset, coarse and fine phases and high at all other times.
- R8: A trip rising edge that arrives outside its own phase is ignored. A trip level that was already high when its phase began does not trigger that phase.
- R9: If the phase input is low at a clock edge during preset, coarse or fine, the block goes idle after that edge: ramps off, sampling control low, timeout high. Timeout stays high until reset. If the phase input falls during the shutdown delay, the block goes idle without setting timeout.
- R10: After a completed sequence, every enable stays low until the next rising edge of the phase input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sequencing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_phase | input | 1 | Half-clock phase, high during charge transfer |
| coarse_trip | input | 1 | Coarse detector trip, asynchronous |
| fine_trip | input | 1 | Fine detector trip, asynchronous |
| preset_o | output | 1 | Preset pulse |
| coarse_en_o | output | 1 | Coarse ramp current enable |
| fine_en_o | output | 1 | Fine ramp current enable |
| strobe_o | output | 1 | Early strobe to the next stage's sub-ADC |
| sample_o | output | 1 | Sampling-switch control (high = closed) |
| pullup_o | output | 1 | Stage output pull-up enable |
| bias_hi_o | output | 1 | Large preamplifier bias enable |
| bias_lo_o | output | 1 | Small preamplifier bias enable |
| timeout_o | output | 1 | Sticky missed-zero-crossing flag |

## Verification
The hardest cases to reach from the ports are those where timing decides the outcome. One is a fine trip that arrives during the coarse phase and then goes away. Another is a phase input that falls in the middle of the shutdown delay. Both depend on where a trip lands relative to the synchronizer latency. The stimulus therefore places each trip edge a counted number of fast cycles after the phase rises: a fine pulse during the coarse ramp, a phase drop four cycles after the fine trip, and a run with no fine trip at all. A behavioural model predicts every output on every cycle, so a one-cycle slip in any of these windows is caught.

// File: rtl/ztx_pkg.sv
package ztx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_PRESET = 3'd1,
      ST_COARSE = 3'd2,
      ST_FINE   = 3'd3,
      ST_SHUT   = 3'd4,
      ST_DONE   = 3'd5
   } ztx_state_e;

   localparam int unsigned TRIP_COARSE = 0;
   localparam int unsigned TRIP_FINE   = 1;
   localparam int unsigned TRIP_COUNT  = 2;
endpackage

// File: rtl/ztx_trip_sync.sv
module ztx_trip_sync #(
   parameter int unsigned N_BITS = 2,
   parameter int unsigned DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_BITS-1:0] async_i,
   output logic [N_BITS-1:0] rise_o
);
   if (DEPTH < 2) begin : g_depth_bad
      $error("ztx_trip_sync: DEPTH must be at least 2");
   end

   for (genvar b = 0; b < N_BITS; b++) begin : g_bit
      logic [DEPTH-1:0] chain;
      logic             last;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
         end else begin
            chain <= {chain[DEPTH-2:0], async_i[b]};
            last  <= chain[DEPTH-1];
         end
      end

      assign rise_o[b] = chain[DEPTH-1] & ~last;
   end
endmodule

// File: rtl/ztx_span_timer.sv
module ztx_span_timer #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic [W-1:0] limit_i,
   output logic         done_o
);
   logic [W-1:0] cnt;

   assign done_o = run_i && (cnt == (limit_i - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run_i || done_o) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ztx_seq_fsm.sv
module ztx_seq_fsm
   import ztx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       xfer_phase,
   input  logic       ctrip_rise,
   input  logic       ftrip_rise,
   input  logic       tmr_done,
   output logic       tmr_run,
   output logic       tmr_sel_shut,
   output ztx_state_e state_o,
   output logic       strobe_o,
   output logic       timeout_o
);
   ztx_state_e state, state_nx;
   logic       xfer_q;
   logic       start;
   logic       abort;
   logic       strobe_nx;

   assign start = xfer_phase & ~xfer_q;
   assign abort = ~xfer_phase &&
                  (state == ST_PRESET || state == ST_COARSE || state == ST_FINE);

   always_comb begin
      state_nx  = state;
      strobe_nx = 1'b0;
      unique case (state)
         ST_IDLE:   if (start) state_nx = ST_PRESET;
         ST_PRESET: if (!xfer_phase) state_nx = ST_IDLE;
                    else if (tmr_done) state_nx = ST_COARSE;
         ST_COARSE: if (!xfer_phase) state_nx = ST_IDLE;
                    else if (ctrip_rise) begin
                       state_nx  = ST_FINE;
                       strobe_nx = 1'b1;
                    end
         ST_FINE:   if (!xfer_phase) state_nx = ST_IDLE;
                    else if (ftrip_rise) state_nx = ST_SHUT;
         ST_SHUT:   if (!xfer_phase) state_nx = ST_IDLE;
                    else if (tmr_done) state_nx = ST_DONE;
         ST_DONE:   if (!xfer_phase) state_nx = ST_IDLE;
         default:   state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         xfer_q    <= 1'b0;
         strobe_o  <= 1'b0;
         timeout_o <= 1'b0;
      end else begin
         state    <= state_nx;
         xfer_q   <= xfer_phase;
         strobe_o <= strobe_nx;
         if (abort) timeout_o <= 1'b1;
      end
   end

   assign tmr_run      = (state == ST_PRESET) || (state == ST_SHUT);
   assign tmr_sel_shut = (state == ST_SHUT);
   assign state_o      = state;
endmodule

// File: rtl/ztx_phase_seq.sv
module ztx_phase_seq
   import ztx_pkg::*;
#(
   parameter int unsigned PRESET_CYC = 2,
   parameter int unsigned SHUT_CYC   = 3,
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_phase,
   input  logic coarse_trip,
   input  logic fine_trip,
   output logic preset_o,
   output logic coarse_en_o,
   output logic fine_en_o,
   output logic strobe_o,
   output logic sample_o,
   output logic pullup_o,
   output logic bias_hi_o,
   output logic bias_lo_o,
   output logic timeout_o
);
   localparam int unsigned SPAN_MAX = (PRESET_CYC > SHUT_CYC) ? PRESET_CYC : SHUT_CYC;
   localparam int unsigned TMR_W    = $clog2(SPAN_MAX + 1);
   localparam logic [TMR_W-1:0] PRE_LIM  = TMR_W'(PRESET_CYC);
   localparam logic [TMR_W-1:0] SHUT_LIM = TMR_W'(SHUT_CYC);

   if (PRESET_CYC < 1) begin : g_preset_bad
      $error("ztx_phase_seq: PRESET_CYC must be at least 1");
   end
   if (SHUT_CYC < 1) begin : g_shut_bad
      $error("ztx_phase_seq: SHUT_CYC must be at least 1");
   end

   logic [TRIP_COUNT-1:0] trip_raw;
   logic [TRIP_COUNT-1:0] trip_rise;
   logic                  tmr_run;
   logic                  tmr_sel_shut;
   logic                  tmr_done;
   logic [TMR_W-1:0]      tmr_limit;
   ztx_state_e            state;

   assign trip_raw[TRIP_COARSE] = coarse_trip;
   assign trip_raw[TRIP_FINE]   = fine_trip;

   ztx_trip_sync #(
      .N_BITS (TRIP_COUNT),
      .DEPTH  (SYNC_DEPTH)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (trip_raw),
      .rise_o  (trip_rise)
   );

   assign tmr_limit = tmr_sel_shut ? SHUT_LIM : PRE_LIM;

   ztx_span_timer #(
      .W (TMR_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (tmr_run),
      .limit_i (tmr_limit),
      .done_o  (tmr_done)
   );

   ztx_seq_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .xfer_phase   (xfer_phase),
      .ctrip_rise   (trip_rise[TRIP_COARSE]),
      .ftrip_rise   (trip_rise[TRIP_FINE]),
      .tmr_done     (tmr_done),
      .tmr_run      (tmr_run),
      .tmr_sel_shut (tmr_sel_shut),
      .state_o      (state),
      .strobe_o     (strobe_o),
      .timeout_o    (timeout_o)
   );

   always_comb begin
      preset_o    = (state == ST_PRESET);
      coarse_en_o = (state == ST_PRESET) || (state == ST_COARSE);
      fine_en_o   = (state == ST_PRESET) || (state == ST_COARSE) ||
                    (state == ST_FINE)   || (state == ST_SHUT);
      sample_o    = (state == ST_PRESET) || (state == ST_COARSE) || (state == ST_FINE);
      pullup_o    = !sample_o;
      bias_hi_o   = (state == ST_COARSE) || (state == ST_FINE);
      bias_lo_o   = 1'b1;
   end
endmodule

// File: rtl/ztx_phase_seq_chk.sv
module ztx_phase_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic preset_o,
   input logic coarse_en_o,
   input logic fine_en_o,
   input logic strobe_o,
   input logic sample_o,
   input logic pullup_o,
   input logic bias_hi_o,
   input logic timeout_o
);
   assert_preset_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(preset_o) |-> (coarse_en_o && fine_en_o && sample_o));

   assert_coarse_needs_fine_R3: assert property (@(posedge clk) disable iff (!rst_n)
      coarse_en_o |-> fine_en_o);

   assert_strobe_at_coarse_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> ($fell(coarse_en_o) && fine_en_o));

   assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o);

   assert_sample_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sample_o) |-> (fine_en_o || timeout_o));

   assert_bias_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bias_hi_o |-> (!preset_o && !pullup_o));

   assert_pullup_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pullup_o |-> (!sample_o && !coarse_en_o));

   assert_timeout_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> timeout_o);
endmodule

bind ztx_phase_seq ztx_phase_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .preset_o    (preset_o),
   .coarse_en_o (coarse_en_o),
   .fine_en_o   (fine_en_o),
   .strobe_o    (strobe_o),
   .sample_o    (sample_o),
   .pullup_o    (pullup_o),
   .bias_hi_o   (bias_hi_o),
   .timeout_o   (timeout_o)
);

// File: tb/sim_ztx_phase_seq.sv
module sim_ztx_phase_seq;
   localparam int P_CYC = 2;
   localparam int S_CYC = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic xfer = 1'b0;
   logic ctrip = 1'b0;
   logic ftrip = 1'b0;
   logic preset_o, coarse_en_o, fine_en_o, strobe_o, sample_o;
   logic pullup_o, bias_hi_o, bias_lo_o, timeout_o;

   int nchk = 0;
   int nbad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   ztx_phase_seq #(.PRESET_CYC(P_CYC), .SHUT_CYC(S_CYC), .SYNC_DEPTH(2)) u0 (
      .clk(clk), .rst_n(rst_n), .xfer_phase(xfer),
      .coarse_trip(ctrip), .fine_trip(ftrip),
      .preset_o(preset_o), .coarse_en_o(coarse_en_o), .fine_en_o(fine_en_o),
      .strobe_o(strobe_o), .sample_o(sample_o), .pullup_o(pullup_o),
      .bias_hi_o(bias_hi_o), .bias_lo_o(bias_lo_o), .timeout_o(timeout_o)
   );

   // behavioural reference: phase 0 idle,1 preset,2 coarse,3 fine,4 shutdown,5 done
   int ph = 0, span = 0, strb = 0, tmo = 0, xq = 0;
   int cq[$] = '{0, 0, 0};
   int fq[$] = '{0, 0, 0};

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; span = 0; strb = 0; tmo = 0; xq = 0;
         cq = '{0, 0, 0}; fq = '{0, 0, 0};
      end else begin
         int nph, nspan, nstrb;
         bit c_edge, f_edge;
         c_edge = (cq[1] == 1) && (cq[2] == 0);
         f_edge = (fq[1] == 1) && (fq[2] == 0);
         nph = ph; nstrb = 0; nspan = 0;
         if (ph == 0) begin
            if (xfer && xq == 0) nph = 1;
         end else if (!xfer) begin
            if (ph >= 1 && ph <= 3) tmo = 1;
            nph = 0;
         end else if (ph == 1) begin
            if (span == P_CYC - 1) nph = 2; else nspan = span + 1;
         end else if (ph == 2) begin
            if (c_edge) begin nph = 3; nstrb = 1; end
         end else if (ph == 3) begin
            if (f_edge) nph = 4;
         end else if (ph == 4) begin
            if (span == S_CYC - 1) nph = 5; else nspan = span + 1;
         end
         ph = nph; span = nspan; strb = nstrb;
         xq = xfer;
         void'(cq.pop_back()); cq.push_front(int'(ctrip));
         void'(fq.pop_back()); fq.push_front(int'(ftrip));
      end
   end

   task automatic chk(string tag, logic act, logic exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   bit track = 0;
   always @(negedge clk) begin
      if (rst_n && track && !finished) begin
         chk("R2 preset",      preset_o,    ph == 1);
         chk("R3 coarse_en",   coarse_en_o, ph == 1 || ph == 2);
         chk("R5 fine_en",     fine_en_o,   ph >= 1 && ph <= 4);
         chk("R4 strobe",      strobe_o,    strb == 1);
         chk("R5 sample",      sample_o,    ph >= 1 && ph <= 3);
         chk("R7 pullup",      pullup_o,    !(ph >= 1 && ph <= 3));
         chk("R6 bias_hi",     bias_hi_o,   ph == 2 || ph == 3);
         chk("R6 bias_lo",     bias_lo_o,   1'b1);
         chk("R9 timeout",     timeout_o,   tmo == 1);
      end
   end

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_xfer(int c_lat, int f_lat, int hold);
      xfer = 1'b1;
      wait_n(c_lat);
      ctrip = 1'b1;
      wait_n(f_lat);
      ftrip = 1'b1;
      wait_n(hold);
      xfer = 1'b0; ctrip = 1'b0; ftrip = 1'b0;
      wait_n(5);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      // R1: reset state
      chk("R1 preset",  preset_o,    1'b0);
      chk("R1 coarse",  coarse_en_o, 1'b0);
      chk("R1 fine",    fine_en_o,   1'b0);
      chk("R1 sample",  sample_o,    1'b0);
      chk("R1 strobe",  strobe_o,    1'b0);
      chk("R1 timeout", timeout_o,   1'b0);
      chk("R1 pullup",  pullup_o,    1'b1);
      chk("R1 bias_lo", bias_lo_o,   1'b1);
      chk("R1 bias_hi", bias_hi_o,   1'b0);
      track = 1;
      wait_n(2);

      // nominal transfer; check R10 while phase stays high after completion
      xfer = 1'b1;
      wait_n(6); ctrip = 1'b1;
      wait_n(5); ftrip = 1'b1;
      wait_n(12);
      chk("R10 coarse idle", coarse_en_o, 1'b0);
      chk("R10 fine idle",   fine_en_o,   1'b0);
      chk("R10 preset idle", preset_o,    1'b0);
      xfer = 1'b0; ctrip = 1'b0; ftrip = 1'b0;
      wait_n(5);

      // shorter latencies
      run_xfer(4, 3, 20);

      // R8: stray fine pulse during coarse phase is ignored
      xfer = 1'b1;
      wait_n(5);
      ftrip = 1'b1; wait_n(1); ftrip = 1'b0;
      wait_n(4);
      chk("R8 sample held", sample_o,    1'b1);
      chk("R8 coarse held", coarse_en_o, 1'b1);
      ctrip = 1'b1;
      wait_n(6); ftrip = 1'b1;
      wait_n(10);
      xfer = 1'b0; ctrip = 1'b0; ftrip = 1'b0;
      wait_n(5);

      // R8: fine level already high when fine phase opens never triggers
      xfer = 1'b1; ftrip = 1'b1;
      wait_n(5); ctrip = 1'b1;
      wait_n(8);
      chk("R8 level ignored", sample_o, 1'b1);
      xfer = 1'b0; ctrip = 1'b0; ftrip = 1'b0;
      wait_n(2);
      chk("R9 timeout set", timeout_o, 1'b1);
      chk("R9 sample low",  sample_o,  1'b0);
      chk("R9 ramps off",   fine_en_o, 1'b0);
      wait_n(4);

      // R9: phase drops during shutdown delay, timeout remains sticky
      run_xfer(5, 4, 4);
      chk("R9 sticky", timeout_o, 1'b1);

      // missing fine trip once more, then a normal run afterwards
      xfer = 1'b1;
      wait_n(5); ctrip = 1'b1;
      wait_n(12);
      xfer = 1'b0; ctrip = 1'b0;
      wait_n(4);
      run_xfer(7, 6, 9);
      chk("R9 sticky end", timeout_o, 1'b1);

      finish_run();
   end
endmodule